// File: doc/BRIEF.md
# PCI Configuration Port Router

This block sits on the I/O-port path of a processor and decides where each port access goes. It holds the 32-bit configuration-address register that software loads through a dword port. Every request names a 16-bit port, a byte count and a direction. The block answers each request with exactly one routed target, one clock later.

There are three possible targets. A dword access to the address port selects the configuration-address register itself. An access to the four-byte data window selects a configuration-space address, built from the stored register, but only while the register's top bit enables the window. Every other port becomes a plain I/O-space address. When the window is disabled, the access completes without error. A read returns all ones and a write is dropped.

The configuration-space and I/O-space transfers that follow the routing belong to other blocks.

Top module: `pcicfg_port_router`

## Requirements
- R1: After reset, no response is pending, and the configuration-address register reads back as zero.
- R2: A request with `req_bytes` equal to 4 on port 0xCF8 is routed with code 1 (register). A write stores all 32 bits of `req_wdata`, and the new value is in effect for the very next request.
- R3: A register-routed read returns the stored 32-bit value on `rsp_rdata`, with `rsp_addr` zero and `rsp_wr` low.
- R4: A request on port 0xCF8 with `req_bytes` other than 4 is routed with code 0 (I/O), exactly like any other port.
- R5: While register bit 31 is set, any request on ports 0xCFC to 0xCFF is routed with code 2 (configuration). `rsp_addr` equals `CFG_PREFIX` OR register bits 30:2 placed at address bits 30:2 OR the port's bits 1:0 at address bits 1:0. A write is forwarded with `rsp_wr` high.
- R6: While register bit 31 is clear, a request on ports 0xCFC to 0xCFF is routed with code 3 (dropped). A read returns 0xFFFFFFFF, and a write is not forwarded (`rsp_wr` low). `rsp_addr` is zero.
- R7: Any other port is routed with code 0. `rsp_addr` is `IO_PREFIX` OR the 16-bit port, and a write is forwarded with `rsp_wr` high. Ports just outside the window, such as 0xCFB and 0xD00, count as other ports.
- R8: `rsp_valid` is high in the cycle after each accepted request and low in the cycle after a cycle without one.
- R9: Writes that are routed to I/O space, to configuration space, or as dropped leave the configuration-address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 16 | I/O port number |
| req_bytes | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data (used for the register) |
| rsp_valid | output | 1 | Routed result valid |
| rsp_route | output | 2 | 0 I/O, 1 register, 2 configuration, 3 dropped |
| rsp_addr | output | ADDR_W | Routed address with target prefix |
| rsp_rdata | output | 32 | Register value, all ones, or zero |
| rsp_wr | output | 1 | Write forwarded downstream |

## Verification
The port is swept across the address port, every byte of the data window, the ports on either side of the window, and distant ports. This separates exact-match decoding from range decoding. At the address port, sizes 1, 2 and 4 are all tried, which exposes a size check that is missing or too broad. The window is accessed with the enable bit both clear and set, and the stored register carries nonzero low bits. This shows whether the enable gates the route and whether bits 1:0 of the register leak into the configuration address. Back-to-back requests in which a register write is followed at once by a window access confirm that the new value is in effect on the next cycle.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int PORT_W = 16;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        RT_IO    = 2'd0,
        RT_CADDR = 2'd1,
        RT_CFG   = 2'd2,
        RT_ABORT = 2'd3
    } route_e;

    typedef struct packed {
        route_e route;
        logic   fwd_wr;    // write goes downstream
        logic   caddr_wr;  // load the address register
        logic   ret_reg;   // read data comes from the register
        logic   ret_ones;  // read data is all ones
    } decode_t;

    // true when the port lies in the 4-byte window that starts at base
    function automatic logic in_window(input logic [PORT_W-1:0] port,
                                       input logic [PORT_W-1:0] base);
        return port[PORT_W-1:2] == base[PORT_W-1:2];
    endfunction

endpackage

// File: rtl/pcicfg_classify.sv
module pcicfg_classify
    import pcicfg_pkg::*;
#(
    parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
    parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
    input  logic [PORT_W-1:0] port,
    input  logic [2:0]        bytes,
    input  logic              write,
    input  logic              win_en,
    output decode_t           dec
);
    logic hit_caddr;
    logic hit_win;

    assign hit_caddr = (port == ADDR_PORT) && (bytes == 3'd4);
    assign hit_win   = in_window(port, DATA_PORT);

    always_comb begin
        dec = '{route: RT_IO, fwd_wr: 1'b0, caddr_wr: 1'b0,
                ret_reg: 1'b0, ret_ones: 1'b0};
        if (hit_caddr) begin
            dec.route    = RT_CADDR;
            dec.caddr_wr = write;
            dec.ret_reg  = !write;
        end else if (hit_win) begin
            if (win_en) begin
                dec.route  = RT_CFG;
                dec.fwd_wr = write;
            end else begin
                dec.route    = RT_ABORT;
                dec.ret_ones = !write;
            end
        end else begin
            dec.route  = RT_IO;
            dec.fwd_wr = write;
        end
    end
endmodule

// File: rtl/pcicfg_addr_reg.sv
module pcicfg_addr_reg
    import pcicfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q,
    output logic              win_en
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wdata;
    end

    assign win_en = q[DATA_W-1];
endmodule

// File: rtl/pcicfg_resp.sv
module pcicfg_resp
    import pcicfg_pkg::*;
#(
    parameter int                ADDR_W     = 36,
    parameter logic [ADDR_W-1:0] CFG_PREFIX = 36'h4_0000_0000,
    parameter logic [ADDR_W-1:0] IO_PREFIX  = 36'h8_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  decode_t           dec,
    input  logic [PORT_W-1:0] port,
    input  logic [DATA_W-1:0] caddr,
    output logic              out_valid,
    output logic [1:0]        out_route,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_rdata,
    output logic              out_wr
);
    localparam int CFG_OFS_W = DATA_W - 1;

    logic [CFG_OFS_W-1:0] cfg_ofs;
    logic [ADDR_W-1:0]    addr_d;
    logic [DATA_W-1:0]    rdata_d;

    assign cfg_ofs = {caddr[DATA_W-2:2], port[1:0]};

    always_comb begin
        unique case (dec.route)
            RT_IO:   addr_d = IO_PREFIX  | ADDR_W'(port);
            RT_CFG:  addr_d = CFG_PREFIX | ADDR_W'(cfg_ofs);
            default: addr_d = '0;
        endcase
        if (dec.ret_reg)       rdata_d = caddr;
        else if (dec.ret_ones) rdata_d = '1;
        else                   rdata_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_route <= RT_IO;
            out_addr  <= '0;
            out_rdata <= '0;
            out_wr    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_route <= dec.route;
                out_addr  <= addr_d;
                out_rdata <= rdata_d;
                out_wr    <= dec.fwd_wr;
            end
        end
    end
endmodule

// File: rtl/pcicfg_port_router.sv
module pcicfg_port_router
    import pcicfg_pkg::*;
#(
    parameter int                ADDR_W     = 36,
    parameter logic [ADDR_W-1:0] CFG_PREFIX = 36'h4_0000_0000,
    parameter logic [ADDR_W-1:0] IO_PREFIX  = 36'h8_0000_0000,
    parameter logic [15:0]       ADDR_PORT  = 16'hCF8,
    parameter logic [15:0]       DATA_PORT  = 16'hCFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [15:0]       req_port,
    input  logic [2:0]        req_bytes,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_route,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_wr
);
    decode_t           dec;
    logic [DATA_W-1:0] caddr_q;
    logic              win_en;

    pcicfg_classify #(
        .ADDR_PORT (ADDR_PORT),
        .DATA_PORT (DATA_PORT)
    ) u_classify (
        .port   (req_port),
        .bytes  (req_bytes),
        .write  (req_write),
        .win_en (win_en),
        .dec    (dec)
    );

    pcicfg_addr_reg u_addr_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req_valid && dec.caddr_wr),
        .wdata  (req_wdata),
        .q      (caddr_q),
        .win_en (win_en)
    );

    pcicfg_resp #(
        .ADDR_W     (ADDR_W),
        .CFG_PREFIX (CFG_PREFIX),
        .IO_PREFIX  (IO_PREFIX)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .dec       (dec),
        .port      (req_port),
        .caddr     (caddr_q),
        .out_valid (rsp_valid),
        .out_route (rsp_route),
        .out_addr  (rsp_addr),
        .out_rdata (rsp_rdata),
        .out_wr    (rsp_wr)
    );
endmodule

// File: rtl/pcicfg_port_router_chk.sv
module pcicfg_port_router_chk #(
    parameter int                ADDR_W     = 36,
    parameter logic [ADDR_W-1:0] CFG_PREFIX = 36'h4_0000_0000,
    parameter logic [ADDR_W-1:0] IO_PREFIX  = 36'h8_0000_0000,
    parameter logic [15:0]       ADDR_PORT  = 16'hCF8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [15:0]       req_port,
    input logic [2:0]        req_bytes,
    input logic              req_write,
    input logic [31:0]       req_wdata,
    input logic [31:0]       caddr_q,
    input logic              rsp_valid,
    input logic [1:0]        rsp_route,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_wr
);
    // R8
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R8
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    caddr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_port == ADDR_PORT && req_bytes == 3'd4)
        |=> caddr_q == $past(req_wdata));

    // R9
    caddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_port == ADDR_PORT && req_bytes == 3'd4)
        |=> $stable(caddr_q));

    // R6
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 2'd3) |-> (!rsp_wr && rsp_addr == '0));

    // R5
    cfg_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 2'd2)
        |-> rsp_addr[ADDR_W-1:31] == CFG_PREFIX[ADDR_W-1:31]);

    // R7
    io_port_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 2'd0)
        |-> (rsp_addr[15:0] == $past(req_port)
             && rsp_addr[ADDR_W-1:16] == IO_PREFIX[ADDR_W-1:16]));
endmodule

bind pcicfg_port_router pcicfg_port_router_chk #(
    .ADDR_W     (ADDR_W),
    .CFG_PREFIX (CFG_PREFIX),
    .IO_PREFIX  (IO_PREFIX),
    .ADDR_PORT  (ADDR_PORT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_bytes (req_bytes),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .caddr_q   (caddr_q),
    .rsp_valid (rsp_valid),
    .rsp_route (rsp_route),
    .rsp_addr  (rsp_addr),
    .rsp_wr    (rsp_wr)
);

// File: tb/pcicfg_port_router_tb.sv
module pcicfg_port_router_tb;
    localparam int          ADDR_W = 36;
    localparam logic [35:0] CFGP   = 36'h4_0000_0000;
    localparam logic [35:0] IOP    = 36'h8_0000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [15:0]       req_port  = '0;
    logic [2:0]        req_bytes = 3'd1;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_route;
    logic [ADDR_W-1:0] rsp_addr;
    logic [31:0]       rsp_rdata;
    logic              rsp_wr;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    logic [31:0] m_caddr = '0;

    always #5 clk = ~clk;

    pcicfg_port_router u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_port  (req_port),
        .req_bytes (req_bytes),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_route (rsp_route),
        .rsp_addr  (rsp_addr),
        .rsp_rdata (rsp_rdata),
        .rsp_wr    (rsp_wr)
    );

    task automatic check(input string tag, input logic ok, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // one request, compared one cycle later; call at a negedge
    task automatic access(input string tag, input logic [15:0] p,
                          input logic [2:0] b, input logic w,
                          input logic [31:0] d);
        logic [1:0]  e_route;
        logic [35:0] e_addr;
        logic [31:0] e_rdata;
        logic        e_wr;
        req_valid = 1'b1; req_port = p; req_bytes = b;
        req_write = w;    req_wdata = d;
        e_addr = '0; e_rdata = '0; e_wr = 1'b0;
        if (p == 16'hCF8 && b == 3'd4) begin
            e_route = 2'd1;
            if (!w) e_rdata = m_caddr;
        end else if (p >= 16'hCFC && p <= 16'hCFF) begin
            if (m_caddr[31]) begin
                e_route = 2'd2;
                e_addr  = CFGP | 36'((m_caddr & 32'h7FFF_FFFC) | {30'd0, p[1:0]});
                e_wr    = w;
            end else begin
                e_route = 2'd3;
                if (!w) e_rdata = 32'hFFFF_FFFF;
            end
        end else begin
            e_route = 2'd0;
            e_addr  = IOP | 36'(p);
            e_wr    = w;
        end
        if (p == 16'hCF8 && b == 3'd4 && w) m_caddr = d;
        @(negedge clk);
        check(tag, rsp_valid === 1'b1 && rsp_route === e_route &&
                   rsp_addr === e_addr && rsp_rdata === e_rdata &&
                   rsp_wr === e_wr,
              $sformatf("port %h bytes %0d wr %0b: got v%0b rt%0d a%h d%h w%0b exp v1 rt%0d a%h d%h w%0b",
                        p, b, w, rsp_valid, rsp_route, rsp_addr, rsp_rdata,
                        rsp_wr, e_route, e_addr, e_rdata, e_wr));
        req_valid = 1'b0;
    endtask

    task automatic idle(input string tag);
        req_valid = 1'b0;
        @(negedge clk);
        check(tag, rsp_valid === 1'b0,
              $sformatf("idle cycle: rsp_valid got %0b exp 0", rsp_valid));
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", rsp_valid === 1'b0,
              $sformatf("rsp_valid in reset got %0b exp 0", rsp_valid));
        rst = 1'b0;
        idle("R8");
        access("R1", 16'hCF8, 3'd4, 1'b0, 32'h0);
        // R7: ordinary ports
        access("R7", 16'h0080, 3'd1, 1'b0, 32'h0);
        access("R7", 16'h03F8, 3'd1, 1'b1, 32'h55);
        access("R7", 16'hFFFF, 3'd2, 1'b1, 32'h0);
        // R4: address port with a narrow access
        access("R4", 16'hCF8, 3'd1, 1'b1, 32'hDEAD_BEEF);
        access("R4", 16'hCF8, 3'd2, 1'b0, 32'h0);
        access("R9", 16'hCF8, 3'd4, 1'b0, 32'h0);
        // R6: window disabled
        access("R6", 16'hCFC, 3'd4, 1'b0, 32'h0);
        access("R6", 16'hCFE, 3'd1, 1'b1, 32'h1234);
        access("R9", 16'hCF8, 3'd4, 1'b0, 32'h0);
        idle("R8");
        // R2, then window used on the very next request (R5)
        access("R2", 16'hCF8, 3'd4, 1'b1, 32'h8012_345B);
        access("R5", 16'hCFC, 3'd4, 1'b0, 32'h0);
        access("R3", 16'hCF8, 3'd4, 1'b0, 32'h0);
        access("R5", 16'hCFD, 3'd1, 1'b1, 32'hAA);
        access("R5", 16'hCFE, 3'd2, 1'b0, 32'h0);
        access("R5", 16'hCFF, 3'd1, 1'b1, 32'hBB);
        // R7: neighbours of the window
        access("R7", 16'hCFB, 3'd1, 1'b0, 32'h0);
        access("R7", 16'hD00, 3'd1, 1'b1, 32'h0);
        access("R7", 16'hCF9, 3'd1, 1'b0, 32'h0);
        // R9: writes elsewhere leave the register alone
        access("R9", 16'hCFC, 3'd4, 1'b1, 32'h0000_0000);
        access("R9", 16'h0CF0, 3'd4, 1'b1, 32'hFFFF_FFFF);
        access("R9", 16'hCF8, 3'd4, 1'b0, 32'h0);
        // disable the window again
        access("R2", 16'hCF8, 3'd4, 1'b1, 32'h7FFF_FFFC);
        access("R6", 16'hCFF, 3'd1, 1'b0, 32'h0);
        access("R3", 16'hCF8, 3'd4, 1'b0, 32'h0);
        access("R2", 16'hCF8, 3'd4, 1'b1, 32'hFFFF_FFFF);
        access("R5", 16'hCFF, 3'd4, 1'b0, 32'h0);
        idle("R8");
        idle("R8");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule